// File: doc/BRIEF.md
# Six-Bit Link Word Deserializer

This block rebuilds a 24-bit word that a sender puts on a six-wire data bus as four 6-bit groups in a row. A forwarded strobe line goes with the data. It rests high. For each group the sender pulls it low while it sets up the data, then lets it go high again once the group is ready. The receiver does not run on that strobe. It runs on its own system clock, passes the strobe and the data lines through a synchronizer, and treats each 0-to-1 change of the synchronized strobe as "take the group now".

Each group that is taken goes into its own 6-bit slice of an assembly register. The first group of a word fills the low end and the last group fills the high end. When the fourth group arrives, the complete word goes to an output register and a valid flag is high for one clock. A synchronous reset and a synchronous resync input both drop any word that is only partly received. After either one, the next strobe rise is taken as the first group of a new word.

Top module: `gdes_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wordOut` is zero and `wordValid` is low, and the group count is zero.
- R2: A strobe that is already high when reset ends is not counted as a rise. After reset, exactly four real rises are needed before a word is reported, and three rises produce nothing.
- R3: The first group after reset or resync goes to bits 5..0, the second to bits 11..6, the third to bits 17..12 and the fourth to bits 23..18 of `wordOut`.
- R4: The group stored is the value on `dataIn` when `strobeIn` rises, provided that value has been stable for at least 2 clocks before the rise. This holds for any low-phase length of 2 cycles or more and any high-phase length of 4 cycles or more.
- R5: `wordValid` is high for exactly one clock per completed word. It is first seen high after the third rising clock edge following the fourth strobe rise at the input (2 synchronizer stages plus 1 output register).
- R6: `wordOut` keeps its value between completed words. Groups of a word that is not yet complete do not change it.
- R7: A one-cycle high on `resync` drops the partial word and sets the group count to zero. The next rise is stored as bits 5..0.
- R8: The group count wraps to zero after the fourth group, so words sent back to back without resync are each rebuilt correctly.
- R9: Reset asserted in the middle of a word drops the partial word and clears `wordOut`. The word that follows is rebuilt from its first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the receiver |
| rst | input | 1 | Synchronous reset, active high |
| resync | input | 1 | Synchronous frame restart, active high |
| strobeIn | input | 1 | Forwarded group strobe, rests high, rises when a group is ready |
| dataIn | input | 6 | Group data lines from the sender |
| wordOut | output | 24 | Last complete word |
| wordValid | output | 1 | One-cycle pulse when `wordOut` is updated |

## Verification
Random 24-bit words are sent back to back, with a random low length and high length for every strobe phase. These runs show that the slice order and the count wrap are correct, and that capture does not depend on how long the strobe stays in each phase. Directed words exercise each slice separately: distinct small values per group, all ones, and a word built only from the edge bits of each group. A slice swap and a slice shift give different words under these patterns, so a wrong order shows up. Partial words cut off by resync and by reset check that the stored output stays unchanged and that the next rise lands in the lowest slice. Holding the strobe high from reset onward and then sending only three groups tells a false first rise apart from correct behaviour.

// File: rtl/gdes_pkg.sv
package gdes_pkg;

  localparam int unsigned DEF_GROUP_W    = 6;
  localparam int unsigned DEF_NUM_GROUPS = 4;
  localparam int unsigned DEF_SYNC_STG   = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // drop partial word
    logic capture;  // store synchronized group into selected slice
    logic finish;   // this capture completes the word
  } gdesCtl_t;

endpackage

// File: rtl/gdes_sync.sv
module gdes_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stage[i] <= {W{RST_BIT}};
    end else begin
      stage[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gdes_ctrl.sv
module gdes_ctrl
  import gdes_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS,
  parameter int unsigned CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             stbSync,
  output gdesCtl_t         ctl,
  output logic [CNT_W-1:0] slot
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_GROUPS - 1);

  logic             prevStb;
  logic             rise;
  logic [CNT_W-1:0] grpCnt;

  // History resets high so a resting-high strobe is not a rise
  always_ff @(posedge clk) begin
    if (rst) prevStb <= 1'b1;
    else     prevStb <= stbSync;
  end

  assign rise        = stbSync & ~prevStb;
  assign ctl.clear   = resync;
  assign ctl.capture = rise & ~resync;
  assign ctl.finish  = ctl.capture & (grpCnt == LAST);
  assign slot        = grpCnt;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      grpCnt <= '0;
    end else if (ctl.capture) begin
      grpCnt <= (grpCnt == LAST) ? '0 : grpCnt + 1'b1;
    end
  end

  p_cnt_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grpCnt == '0));

  p_cnt_advance_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> (grpCnt == (($past(grpCnt) == LAST) ? '0 : CNT_W'($past(grpCnt) + 1'b1))));

  p_resync_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    $past(resync) |-> (grpCnt == '0));

endmodule

// File: rtl/gdes_dpath.sv
module gdes_dpath
  import gdes_pkg::*;
#(
  parameter int unsigned GROUP_W    = DEF_GROUP_W,
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS,
  parameter int unsigned CNT_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  gdesCtl_t                      ctl,
  input  logic [CNT_W-1:0]              slot,
  input  logic [GROUP_W-1:0]            dataSync,
  output logic [GROUP_W*NUM_GROUPS-1:0] wordOut,
  output logic                          wordValid
);

  localparam int unsigned WORD_W = GROUP_W * NUM_GROUPS;

  logic [WORD_W-1:0] asmReg;
  wire  [WORD_W-1:0] nextWord;

  // The selected slice takes the new group, the others keep their value
  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : gSlice
    localparam logic [CNT_W-1:0] IDX = CNT_W'(g);
    assign nextWord[g*GROUP_W +: GROUP_W] =
      (slot == IDX) ? dataSync : asmReg[g*GROUP_W +: GROUP_W];
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) asmReg <= '0;
    else if (ctl.capture) asmReg <= nextWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= ctl.finish;
      if (ctl.finish) wordOut <= nextWord;
    end
  end

  p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  p_valid_from_finish_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.finish |=> wordValid);

  p_out_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(wordOut));

  p_resync_asm_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.clear) |-> (asmReg == '0));

endmodule

// File: rtl/gdes_top.sv
module gdes_top
  import gdes_pkg::*;
#(
  parameter int unsigned GROUP_W    = DEF_GROUP_W,
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS,
  parameter int unsigned SYNC_STG   = DEF_SYNC_STG
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          resync,
  input  logic                          strobeIn,
  input  logic [GROUP_W-1:0]            dataIn,
  output logic [GROUP_W*NUM_GROUPS-1:0] wordOut,
  output logic                          wordValid
);

  localparam int unsigned CNT_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic               stbSync;
  logic [GROUP_W-1:0] dataSync;
  gdesCtl_t           ctl;
  logic [CNT_W-1:0]   slot;

  gdes_sync #(.W(1), .STAGES(SYNC_STG), .RST_BIT(1'b1)) u_stbSync (
    .clk(clk), .rst(rst), .d(strobeIn), .q(stbSync)
  );

  gdes_sync #(.W(GROUP_W), .STAGES(SYNC_STG), .RST_BIT(1'b0)) u_dataSync (
    .clk(clk), .rst(rst), .d(dataIn), .q(dataSync)
  );

  gdes_ctrl #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .resync(resync), .stbSync(stbSync),
    .ctl(ctl), .slot(slot)
  );

  gdes_dpath #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .slot(slot), .dataSync(dataSync),
    .wordOut(wordOut), .wordValid(wordValid)
  );

endmodule

// File: tb/gdes_top_tb.sv
module gdes_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        resync = 1'b0;
  logic        strobeIn = 1'b1;
  logic [5:0]  dataIn = '0;
  logic [23:0] wordOut;
  logic        wordValid;

  int nChecks = 0;
  int nFail   = 0;
  int nPulses = 0;
  int expPulses = 0;

  gdes_top u_dut (
    .clk(clk), .rst(rst), .resync(resync), .strobeIn(strobeIn),
    .dataIn(dataIn), .wordOut(wordOut), .wordValid(wordValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && wordValid) nPulses++;

  function automatic logic [23:0] packGroups(input logic [5:0] g0, g1, g2, g3);
    return {g3, g2, g1, g0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendGroup(input logic [5:0] v, input int lowLen, input int highLen,
                           input bit isLast, input logic [23:0] expWord);
    @(negedge clk);
    strobeIn = 1'b0;
    dataIn   = v;
    repeat (lowLen) @(negedge clk);
    strobeIn = 1'b1;
    if (isLast) begin
      @(negedge clk); check(!wordValid, "R5 early pulse", {23'd0, wordValid}, 24'd0);
      @(negedge clk); check(!wordValid, "R5 early pulse", {23'd0, wordValid}, 24'd0);
      @(negedge clk); check(wordValid, "R5 pulse missing", {23'd0, wordValid}, 24'd1);
      check(wordOut == expWord, "R3 R4 word", wordOut, expWord);
      @(negedge clk); check(!wordValid, "R5 pulse width", {23'd0, wordValid}, 24'd0);
      repeat (highLen - 4) @(negedge clk);
      dataIn = '0;
    end else begin
      repeat (highLen) @(negedge clk);
    end
  endtask

  task automatic sendWord(input logic [23:0] w);
    for (int g = 0; g < 4; g++)
      sendGroup(w[g*6 +: 6], 2 + int'($urandom % 4), 4 + int'($urandom % 3), g == 3, w);
    expPulses++;
  endtask

  task automatic finishRun();
    check(nPulses == expPulses, "R5 pulse count", 24'(nPulses), 24'(expPulses));
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [23:0] held;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    check(wordOut == '0, "R1 reset out", wordOut, 24'd0);
    check(!wordValid, "R1 reset valid", {23'd0, wordValid}, 24'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(wordOut == '0 && nPulses == 0, "R1 R2 idle after reset", wordOut, 24'd0);

    // R2: three groups must not finish a word
    sendGroup(6'h11, 3, 4, 1'b0, '0);
    sendGroup(6'h22, 3, 4, 1'b0, '0);
    sendGroup(6'h33, 3, 4, 1'b0, '0);
    check(nPulses == 0, "R2 no word after three rises", 24'(nPulses), 24'd0);
    check(wordOut == '0, "R6 partial leaves output", wordOut, 24'd0);
    sendGroup(6'h2A, 3, 5, 1'b1, packGroups(6'h11, 6'h22, 6'h33, 6'h2A));
    expPulses++;

    // R3: directed slice patterns
    sendWord(packGroups(6'd1, 6'd2, 6'd3, 6'd4));
    sendWord(24'hFFFFFF);
    sendWord(packGroups(6'h21, 6'h00, 6'h21, 6'h00));
    sendWord(packGroups(6'h00, 6'h3F, 6'h00, 6'h01));

    // R4 R8: random words back to back
    for (int i = 0; i < 40; i++) sendWord(24'($urandom));

    // R7: resync drops a partial word
    held = wordOut;
    sendGroup(6'h15, 2, 4, 1'b0, '0);
    sendGroup(6'h2B, 2, 4, 1'b0, '0);
    check(wordOut == held, "R6 output held over partial", wordOut, held);
    @(negedge clk); resync = 1'b1;
    @(negedge clk); resync = 1'b0;
    check(wordOut == held, "R7 resync keeps output", wordOut, held);
    sendWord(24'h5A3C96);

    // R9: reset in the middle of a word
    sendGroup(6'h07, 2, 4, 1'b0, '0);
    sendGroup(6'h38, 2, 4, 1'b0, '0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(wordOut == '0, "R9 reset clears output", wordOut, 24'd0);
    rst = 1'b0;
    sendWord(24'h123456);
    sendWord(24'hA5F00F);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule